// File: doc/BRIEF.md
# Ethernet PHY Bring-Up and Link Monitor

This block brings an external Ethernet PHY out of reset and then keeps watch on its link. When the block leaves its own synchronous reset, it drives the active-low PHY reset pin low for one millisecond and then releases it. It waits a second millisecond so the PHY can finish its internal start-up. Both intervals are counted in system clock cycles, and the cycle counts are derived at elaboration from the clock-frequency parameter.

After bring-up, the block reads the PHY's basic status register (register index 1) over and over. It does this through the command side of a separate MDIO master, using a start/busy handshake. It is a control interface and not a data stream, so it has no valid/ready back-pressure. The block pulses `cmd_start` for one cycle only when `cmd_busy` is low. The master raises `cmd_busy` in the cycle after it accepts the start. When `cmd_busy` falls again, `cmd_rdata` holds the returned status word. The link-status bit of that word (bit 2) drives `link_up`.

The MDIO serialiser, autonegotiation and any register writes are outside this block.

Top module: `phy_link_monitor`

## Requirements
- R1: Count from the last clock edge at which `rst` is high. `phy_rst_n` is 0 for exactly MS clock cycles, where MS = CLK_HZ/1000 (minimum 1).
- R2: After those MS cycles `phy_rst_n` is 1, and it stays 1 until the next `rst`.
- R3: `cmd_start` stays 0 for the first 2·MS cycles after reset. In cycle 2·MS the first `cmd_start` pulse appears.
- R4: `link_up` is 0 from reset until the first status read has completed.
- R5: Every `cmd_start` pulse carries `cmd_rw` = 0 (read), `cmd_reg_addr` = 1 and `cmd_phy_addr` = PHY_ADDR.
- R6: When a read completes, `link_up` takes bit 2 of `cmd_rdata`. No other bit of the word affects it.
- R7: `cmd_start` is asserted only while `cmd_busy` is 0. A read counts as complete at the first cycle in which `cmd_busy` is seen low, at least two cycles after its start.
- R8: `link_up` updates on the clock edge that sees the completing low `cmd_busy`. It holds its value at all other times.
- R9: A synchronous `rst` at any time restarts the whole sequence. This includes driving `phy_rst_n` low again and clearing `link_up`.
- R10: Polling is continuous. The next `cmd_start` comes in the cycle right after `link_up` has been updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| phy_rst_n | output | 1 | Active-low reset to the PHY |
| cmd_start | output | 1 | One-cycle request to the MDIO master |
| cmd_rw | output | 1 | Transfer direction, 0 = read |
| cmd_phy_addr | output | 5 | PHY address for the transfer |
| cmd_reg_addr | output | 5 | Register index for the transfer |
| cmd_busy | input | 1 | MDIO master transfer in progress |
| cmd_rdata | input | 16 | Word returned by the last read |
| link_up | output | 1 | Link status of the PHY |

## Verification
The bench builds the block with CLK_HZ = 20000 and PHY_ADDR = 9. This makes one millisecond equal to 20 cycles, so the full reset and settle sequence, a dozen or more reads and a reset in the middle of a run all fit in a short simulation. A nonzero address also proves that the parameter really reaches `cmd_phy_addr`. The MDIO master model answers each read after a random latency. It returns directed status words first (link bit set together with bits 14 and 5, then every bit set except bit 2) and random words after that.

// File: rtl/phy_link_pkg.sv
package phy_link_pkg;
  typedef enum logic [2:0] {
    ST_HOLD,    // PHY reset pin driven low
    ST_SETTLE,  // PHY released, start-up delay
    ST_ISSUE,   // waiting for an idle master to send a read
    ST_ARM,     // master raising busy
    ST_POLL     // waiting for the read to finish
  } seq_state_t;

  localparam logic [4:0] STATUS_REG_IDX = 5'd1;
  localparam int         LINK_BIT_POS   = 2;
endpackage

// File: rtl/phy_link_timer.sv
module phy_link_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (load)            cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/phy_link_seq.sv
module phy_link_seq
  import phy_link_pkg::*;
#(
  parameter int MS_CYCLES = 1000,
  parameter int CNT_W     = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic             expired,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             phy_rst_n,
  output logic             start,
  output logic             capture
);
  seq_state_t state_q, state_d;

  assign tmr_val = CNT_W'(MS_CYCLES - 1);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    start    = 1'b0;
    capture  = 1'b0;
    unique case (state_q)
      ST_HOLD: if (expired) begin
        state_d  = ST_SETTLE;
        tmr_load = 1'b1;
      end
      ST_SETTLE: if (expired) state_d = ST_ISSUE;
      ST_ISSUE: if (!busy) begin
        start   = 1'b1;
        state_d = ST_ARM;
      end
      ST_ARM: state_d = ST_POLL;
      ST_POLL: if (!busy) begin
        capture = 1'b1;
        state_d = ST_ISSUE;
      end
      default: state_d = ST_HOLD;
    endcase
    if (rst) tmr_load = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_HOLD;
      phy_rst_n <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_HOLD && expired) phy_rst_n <= 1'b1;
    end
  end
endmodule

// File: rtl/phy_link_status.sv
module phy_link_status #(
  parameter int DW      = 16,
  parameter int BIT_POS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [DW-1:0] word,
  output logic          link_up
);
  always_ff @(posedge clk) begin
    if (rst)          link_up <= 1'b0;
    else if (capture) link_up <= word[BIT_POS];
  end
endmodule

// File: rtl/phy_link_monitor.sv
module phy_link_monitor
  import phy_link_pkg::*;
#(
  parameter int         CLK_HZ   = 10_000_000,
  parameter logic [4:0] PHY_ADDR = 5'd0
) (
  input  logic        clk,
  input  logic        rst,
  output logic        phy_rst_n,
  output logic        cmd_start,
  output logic        cmd_rw,
  output logic [4:0]  cmd_phy_addr,
  output logic [4:0]  cmd_reg_addr,
  input  logic        cmd_busy,
  input  logic [15:0] cmd_rdata,
  output logic        link_up
);
  localparam int MS_RAW    = CLK_HZ / 1000;
  localparam int MS_CYCLES = (MS_RAW < 1) ? 1 : MS_RAW;
  localparam int CNT_W     = $clog2(MS_CYCLES + 1);

  logic             tmr_load, tmr_expired, capture;
  logic [CNT_W-1:0] tmr_val;

  phy_link_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  phy_link_seq #(.MS_CYCLES(MS_CYCLES), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .busy      (cmd_busy),
    .expired   (tmr_expired),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .phy_rst_n (phy_rst_n),
    .start     (cmd_start),
    .capture   (capture)
  );

  phy_link_status #(.DW(16), .BIT_POS(LINK_BIT_POS)) u_status (
    .clk     (clk),
    .rst     (rst),
    .capture (capture),
    .word    (cmd_rdata),
    .link_up (link_up)
  );

  assign cmd_rw       = 1'b0;
  assign cmd_phy_addr = PHY_ADDR;
  assign cmd_reg_addr = STATUS_REG_IDX;
endmodule

// File: rtl/phy_link_monitor_chk.sv
module phy_link_monitor_chk #(
  parameter logic [4:0] PHY_ADDR = 5'd0
) (
  input logic       clk,
  input logic       rst,
  input logic       phy_rst_n,
  input logic       cmd_start,
  input logic       cmd_rw,
  input logic [4:0] cmd_phy_addr,
  input logic [4:0] cmd_reg_addr,
  input logic       cmd_busy,
  input logic       link_up
);
  // R1, R9: the edge after a reset leaves the PHY in reset with no link
  a_r1_reset_low: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!phy_rst_n && !link_up));

  // R2: once released, the PHY stays out of reset
  a_r2_stays_high: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(phy_rst_n)) |-> phy_rst_n);

  // R3: no register access while the PHY is in reset
  a_r3_no_early_start: assert property (@(posedge clk) disable iff (rst)
    cmd_start |-> phy_rst_n);

  // R5: every request is a status register read at the configured address
  a_r5_read_fields: assert property (@(posedge clk) disable iff (rst)
    cmd_start |-> (!cmd_rw && cmd_reg_addr == 5'd1 && cmd_phy_addr == PHY_ADDR));

  // R7: requests only go to an idle master
  a_r7_start_when_idle: assert property (@(posedge clk) disable iff (rst)
    cmd_start |-> !cmd_busy);

  // R8: the link flag moves only after the master was seen idle
  a_r8_link_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(link_up) |-> ($past(rst) || !$past(cmd_busy)));
endmodule

bind phy_link_monitor phy_link_monitor_chk #(.PHY_ADDR(PHY_ADDR)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .phy_rst_n    (phy_rst_n),
  .cmd_start    (cmd_start),
  .cmd_rw       (cmd_rw),
  .cmd_phy_addr (cmd_phy_addr),
  .cmd_reg_addr (cmd_reg_addr),
  .cmd_busy     (cmd_busy),
  .link_up      (link_up)
);

// File: tb/phy_link_monitor_bench.sv
module phy_link_monitor_bench;
  localparam int         CLK_PERIOD = 10;
  localparam int         CLK_HZ     = 20_000;
  localparam int         MS         = CLK_HZ / 1000;
  localparam logic [4:0] ADDR       = 5'd9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        phy_rst_n, cmd_start, cmd_rw, link_up;
  logic [4:0]  cmd_phy_addr, cmd_reg_addr;
  logic        m_busy = 1'b0;
  logic [15:0] m_rdata = 16'h0;
  logic [15:0] m_pending = 16'h0;
  int          m_lat = 0;
  int          n_issued = 0;
  int          n_done = 0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit restarted = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_link_monitor #(.CLK_HZ(CLK_HZ), .PHY_ADDR(ADDR)) u_phy_link_monitor (
    .clk          (clk),
    .rst          (rst),
    .phy_rst_n    (phy_rst_n),
    .cmd_start    (cmd_start),
    .cmd_rw       (cmd_rw),
    .cmd_phy_addr (cmd_phy_addr),
    .cmd_reg_addr (cmd_reg_addr),
    .cmd_busy     (m_busy),
    .cmd_rdata    (m_rdata),
    .link_up      (link_up)
  );

  function automatic logic [15:0] pick_word(int n);
    if (n == 0) return 16'h4024;       // bits 14, 5, 2
    if (n == 1) return 16'hFFFB;       // all but bit 2
    return 16'($urandom);
  endfunction

  function automatic logic exp_link(logic [15:0] w);
    return w[2];
  endfunction

  // MDIO master model: busy rises after an accepted start, falls after a random latency
  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 1'b0;
      m_lat  <= 0;
    end else if (!m_busy) begin
      if (cmd_start) begin
        m_busy    <= 1'b1;
        m_lat     <= int'($urandom_range(0, 12));
        m_pending <= pick_word(n_issued);
        n_issued  <= n_issued + 1;
      end
    end else if (m_lat == 0) begin
      m_busy  <= 1'b0;
      m_rdata <= m_pending;
      n_done  <= n_done + 1;
    end else begin
      m_lat <= m_lat - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  int   idx = 0;
  logic exp_l = 1'b0;
  logic prev_busy = 1'b0;
  bit   want_start = 0;

  always @(negedge clk) begin
    if (rst) begin
      idx = 0; exp_l = 1'b0; prev_busy = 1'b0; want_start = 0;
    end else begin
      if (idx == 0 && restarted)
        chk(!phy_rst_n && !link_up, "R9 restart", {phy_rst_n, link_up}, 0);
      if (idx < MS) chk(phy_rst_n == 1'b0, "R1 reset pin low", phy_rst_n, 0);
      else          chk(phy_rst_n == 1'b1, "R2 reset pin high", phy_rst_n, 1);
      if (idx < 2*MS) begin
        chk(!cmd_start, "R3 no early start", cmd_start, 0);
        chk(!link_up, "R4 link low during bring-up", link_up, 0);
      end
      if (idx == 2*MS) chk(cmd_start, "R3 first start", cmd_start, 1);
      if (want_start) chk(cmd_start, "R10 next start", cmd_start, 1);
      want_start = 0;
      if (cmd_start) begin
        chk(!m_busy, "R7 start while idle", m_busy, 0);
        chk(!cmd_rw && cmd_reg_addr == 5'd1 && cmd_phy_addr == ADDR, "R5 fields",
            {cmd_rw, cmd_reg_addr, cmd_phy_addr}, {1'b0, 5'd1, ADDR});
        chk(link_up == exp_l, "R6 link from bit 2", link_up, exp_l);
      end
      if (prev_busy && !m_busy) begin
        chk(link_up == exp_l, "R8 hold until capture", link_up, exp_l);
        exp_l = exp_link(m_rdata);
        want_start = 1;
      end
      prev_busy = m_busy;
      idx++;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    wait (n_done >= 12);
    @(posedge clk);
    #1 rst = 1'b1;
    restarted = 1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    wait (n_done >= 24);
    repeat (5) @(posedge clk);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule